// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Interrupts

This block is a parameterised bank of general-purpose pins (16 by default). Every pin carries its own direction bit; a pin that is an output drives the value held in an output data register, and a pin that is an input is sampled through a two-stage synchroniser. Software reaches the port through a single-cycle write strobe with a register select. Besides loading the whole output word at once, it can set, clear or toggle chosen pins, so that one write never disturbs pins it does not name. A plain status vector reports the level of every pin: the driven value for outputs and the synchronised level for inputs.

Every pin can raise the shared interrupt line. A per-pin sensitivity bit picks level detection (high is active) or edge detection, and a second bit lets an edge-sensitive pin respond to falling edges as well as rising ones. Edge hits are held in sticky flags until software acknowledges them through the clear register. Interrupt enables are changed only through separate set-enable and clear-enable writes. For an output pin, the source of detection is the driven value, so software can raise an interrupt by writing that pin. All ports are plain control and status signals: nothing here streams data, so there is no valid/ready handshake and no back-pressure. A write is taken on every clock edge where `wr_en` is high.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input, the output data word is zero, all interrupt enables are zero, every pin is level-sensitive with rising-only edges, and `irq` is low.
- R2: A write with select 4 loads the direction word; bit i of `pad_oe` equals bit i of `wr_data` (1 = output).
- R3: A write with select 0 loads the whole output data word, seen on `pad_out` after the clock edge.
- R4: Select 1 sets, select 2 clears and select 3 toggles exactly the output data bits where `wr_data` is 1; all other bits keep their value.
- R5: `pin_val` bit i is the output data bit when pin i is an output, and the input level after two synchroniser flops when it is an input (visible after the second rising clock edge following a change of `pad_in`).
- R6: Select 5 sets and select 6 clears exactly the enable bits where `wr_data` is 1; `irq` is the OR, over enabled pins, of each pin's active condition, and stays low for pins whose enable is 0.
- R7: With sensitivity bit 0 (select 7 loads the sensitivity word, 1 = edge), a pin is active while its source is high; an input change reaches `irq` two clock edges after it changes.
- R8: With sensitivity bit 1, a rising edge of the source sets a sticky flag that holds the pin active after the source falls; for an input the flag shows on `irq` three clock edges after the change.
- R9: Select 8 loads the both-edges word; for an edge-sensitive pin with this bit 1 a falling edge also sets the flag, with bit 0 a falling edge is ignored.
- R10: Writing 1 to a pin's bit with select 2 also clears that pin's edge flag; an edge detected in the same cycle wins over the clear, and a pin in level mode keeps no flag.
- R11: For an output pin the source of detection is its driven data bit, so writing that bit raises the interrupt (software trigger) with the same level or edge rules.
- R12: Select codes 9 to 15 change no state: `pad_out`, `pad_oe` and `irq` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 4 | Register select code (see requirements) |
| wr_data | input | NPIN | Write data, one bit per pin |
| pad_in | input | NPIN | Asynchronous pin levels from the pads |
| pad_out | output | NPIN | Output data word driven to the pads |
| pad_oe | output | NPIN | Per-pin output enable (direction) |
| pin_val | output | NPIN | Current pin levels (status) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with NPIN = 4, which makes every 4-bit word small enough to sweep: all pairs of prior output word and write mask for the data-load, set, clear and toggle writes; all combinations of enable-set mask, enable-clear mask and driven data for the interrupt OR; and every pairing of direction word and input level for the status vector. Per-pin timing cases (synchroniser latency, sticky edge flags, falling-edge selection, clearing, software triggering and ignored select codes) are driven on single pins of that same small port, with expected values computed from the requirements.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA    = 4'd0,
    SEL_SET     = 4'd1,
    SEL_CLR     = 4'd2,
    SEL_TGL     = 4'd3,
    SEL_DIR     = 4'd4,
    SEL_IEN_SET = 4'd5,
    SEL_IEN_CLR = 4'd6,
    SEL_EDGE    = 4'd7,
    SEL_BOTH    = 4'd8
  } gpio_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NPIN-1:0]  wr_data,
  output logic [NPIN-1:0]  data_q,
  output logic [NPIN-1:0]  dir_q,
  output logic [NPIN-1:0]  ien_q,
  output logic [NPIN-1:0]  edge_q,
  output logic [NPIN-1:0]  both_q,
  output logic [NPIN-1:0]  flag_clr
);
  logic [NPIN-1:0] data_d, dir_d, ien_d, edge_d, both_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    ien_d  = ien_q;
    edge_d = edge_q;
    both_d = both_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_DATA:    data_d = wr_data;
        SEL_SET:     data_d = data_q | wr_data;
        SEL_CLR:     data_d = data_q & ~wr_data;
        SEL_TGL:     data_d = data_q ^ wr_data;
        SEL_DIR:     dir_d  = wr_data;
        SEL_IEN_SET: ien_d  = ien_q | wr_data;
        SEL_IEN_CLR: ien_d  = ien_q & ~wr_data;
        SEL_EDGE:    edge_d = wr_data;
        SEL_BOTH:    both_d = wr_data;
        default:     ;
      endcase
    end
  end

  assign flag_clr = (wr_en && wr_sel == SEL_CLR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      edge_q <= edge_d;
      both_q <= both_d;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPIN   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [LAST:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else if (STAGES == 1) chain <= async_in[p];
      else chain <= {chain[LAST-1:0], async_in[p]};
    end
    assign sync_out[p] = chain[LAST];
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] src,
  input  logic [NPIN-1:0] edge_mode,
  input  logic [NPIN-1:0] both_edges,
  input  logic [NPIN-1:0] flag_clr,
  output logic [NPIN-1:0] active
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic prev_q, flag_q, hit, flag_d;

    assign hit    = (src[p] & ~prev_q) | (both_edges[p] & ~src[p] & prev_q);
    assign flag_d = edge_mode[p] & (hit | (flag_q & ~flag_clr[p]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= src[p];
        flag_q <= flag_d;
      end
    end

    assign active[p] = edge_mode[p] ? flag_q : src[p];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NPIN-1:0]  wr_data,
  input  logic [NPIN-1:0]  pad_in,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe,
  output logic [NPIN-1:0]  pin_val,
  output logic             irq
);
  logic [NPIN-1:0] data_q, dir_q, ien_q, edge_q, both_q, flag_clr;
  logic [NPIN-1:0] in_sync, src, active;

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_q(data_q), .dir_q(dir_q), .ien_q(ien_q), .edge_q(edge_q),
    .both_q(both_q), .flag_clr(flag_clr)
  );

  gpio_sync #(.NPIN(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
  );

  assign src = (dir_q & data_q) | (~dir_q & in_sync);

  gpio_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .src(src), .edge_mode(edge_q),
    .both_edges(both_q), .flag_clr(flag_clr), .active(active)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign pin_val = src;
  assign irq     = |(ien_q & active);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [NPIN-1:0]  wr_data,
  input logic [NPIN-1:0]  pad_out,
  input logic [NPIN-1:0]  pad_oe,
  input logic [NPIN-1:0]  ien_q,
  input logic             irq
);
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR) |=> pad_oe == $past(wr_data));

  a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA) |=> pad_out == $past(wr_data));

  a_r4_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SET) |=> pad_out == ($past(pad_out) | $past(wr_data)));

  a_r4_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CLR) |=> pad_out == ($past(pad_out) & ~$past(wr_data)));

  a_r4_tgl_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_TGL) |=> pad_out == ($past(pad_out) ^ $past(wr_data)));

  a_r6_ien_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_IEN_SET) |=> (ien_q & $past(wr_data)) == $past(wr_data));

  a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r12_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_BOTH) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .pad_out(pad_out), .pad_oe(pad_oe), .ien_q(ien_q), .irq(irq)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pin_val;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port #(.NPIN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_val(pin_val), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", irq, 0);
    pad_in = ALL;
    cyc(3);
    chk("R1 level default no enable irq", irq, 0);
    pad_in = '0;
    cyc(3);

    // R3, R4 exhaustive data writes
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(4'd0, N'(a)); chk("R3 data load", pad_out, a);
        wr(4'd1, N'(b)); chk("R4 set", pad_out, (a | b) & 15);
        wr(4'd0, N'(a)); wr(4'd2, N'(b)); chk("R4 clear", pad_out, a & ~b & 15);
        wr(4'd0, N'(a)); wr(4'd3, N'(b)); chk("R4 toggle", pad_out, (a ^ b) & 15);
      end
    end

    // R2, R5 direction and status sweep
    for (int d = 0; d < 16; d++) begin
      wr(4'd4, N'(d)); chk("R2 direction", pad_oe, d);
      for (int x = 0; x < 16; x++) begin
        wr(4'd0, N'(~x));
        pad_in = N'(x);
        cyc(2);
        chk("R5 status", pin_val, ((d & ~x) | (~d & x)) & 15);
      end
    end

    // R6, R11 enable set/clear sweep with level software triggers
    wr(4'd4, ALL);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int v = 0; v < 16; v++) begin
          wr(4'd6, ALL); wr(4'd5, N'(a)); wr(4'd6, N'(b)); wr(4'd0, N'(v));
          chk("R6 R11 irq or of enabled", irq, ((a & ~b & v) != 0) ? 1 : 0);
        end
      end
    end

    // R7 input level latency on pin 0
    wr(4'd6, ALL); wr(4'd0, '0); wr(4'd4, '0);
    pad_in = '0; cyc(3);
    wr(4'd5, 4'b0001);
    pad_in = 4'b0001;
    cyc(1); chk("R7 level after one edge", irq, 0);
    cyc(1); chk("R7 level after two edges", irq, 1);
    pad_in = '0;
    cyc(2); chk("R7 level follows low", irq, 0);
    wr(4'd6, 4'b0001);
    pad_in = 4'b0001; cyc(3);
    chk("R6 disabled pin no irq", irq, 0);
    pad_in = '0; cyc(3);

    // R8 rising edge on pin 1, sticky
    wr(4'd6, ALL); wr(4'd7, 4'b0010); wr(4'd8, '0); wr(4'd5, 4'b0010);
    pad_in = 4'b0010;
    cyc(2); chk("R8 edge after two edges", irq, 0);
    cyc(1); chk("R8 edge after three edges", irq, 1);
    pad_in = '0;
    cyc(4); chk("R8 flag sticky after fall", irq, 1);
    // R10 clear flag
    wr(4'd2, 4'b0010); chk("R10 flag cleared", irq, 0);
    // R9 falling ignored when both bit is 0
    pad_in = 4'b0010; cyc(4); wr(4'd2, 4'b0010);
    pad_in = '0; cyc(4);
    chk("R9 falling ignored", irq, 0);
    // R9 both edges
    wr(4'd8, 4'b0010);
    pad_in = 4'b0010; cyc(4); chk("R9 rising with both", irq, 1);
    wr(4'd2, 4'b0010); chk("R10 clear before fall", irq, 0);
    pad_in = '0; cyc(4); chk("R9 falling captured", irq, 1);
    wr(4'd2, 4'b0010);
    // R10 level mode keeps no flag
    pad_in = 4'b0010; cyc(4);
    wr(4'd7, '0); pad_in = '0; cyc(3);
    chk("R10 level mode drops flag", irq, 0);
    wr(4'd7, 4'b0010); cyc(2);
    chk("R10 flag not restored", irq, 0);

    // R11 software edge trigger on output pin 2
    wr(4'd6, ALL); wr(4'd8, '0); wr(4'd4, 4'b0100); wr(4'd0, '0);
    wr(4'd7, 4'b0100); wr(4'd5, 4'b0100);
    wr(4'd1, 4'b0100); chk("R11 edge not yet", irq, 0);
    cyc(1); chk("R11 software edge", irq, 1);
    wr(4'd2, 4'b0100); chk("R11 R10 cleared", irq, 0);

    // R12 unused select codes
    wr(4'd0, 4'b1010); wr(4'd4, 4'b0110);
    for (int s = 9; s < 16; s++) begin
      wr(4'(s), 4'b0101);
      chk("R12 pad_out unchanged", pad_out, 4'b1010);
      chk("R12 pad_oe unchanged", pad_oe, 4'b0110);
      chk("R12 irq unchanged", irq, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule